// File: doc/BRIEF.md
# Feedback-Routed Four-Function-Pair Datapath

This block is a small register datapath with two working registers, A and B, and one combinational function unit. Each register has its own four-way source multiplexer. On every clock edge each register loads the source that its select chooses. The choices are the external data bus, the current value of A, the current value of B, or the result bus. There is no load enable. A register keeps its value only when its source select points back at its own output.

The function unit reads both registers. A result select picks one of eight operations for the result bus: pass, complement, bitwise logic, sum and single-bit shifts. The result bus is a port of the block. It is also one of the register sources, so a register can be updated with a function of its own old contents in one edge.

Users drive the data bus and the three selects each cycle. A controller outside the block sequences the selects to form operations such as load, move, add-and-store and shift-in-place.

Top module: `fbmux_alu`

## Requirements
- R1: Asserting the active-low asynchronous reset `rst_ni` forces both registers to 0 without waiting for a clock edge. Both registers stay 0 for as long as the reset is held.
- R2: The source select code 2'b00 makes the register load `in_bus_i` at the next rising edge. This holds for either register.
- R3: The source select code 2'b01 loads the current A value, and 2'b10 loads the current B value. A register whose select names itself keeps its value.
- R4: The source select code 2'b11 loads the result bus value that was present just before the edge. That value was computed from the old register contents.
- R5: The result select 3'b000 drives A onto the result bus, 3'b001 drives B, and 3'b010 drives the bitwise inverse of A.
- R6: The result select 3'b011 drives A AND B, and 3'b100 drives A OR B, bit by bit.
- R7: The result select 3'b101 drives A + B modulo 2^WIDTH. The carry out of the top bit is dropped.
- R8: The result select 3'b110 shifts A one place toward the MSB, and 3'b111 shifts A one place toward the LSB. In both cases the vacated bit is filled with 0.
- R9: The result bus is combinational. It follows a change of the result select or of the registers within the same cycle, with no clock edge.
- R10: Both registers update at the same edge from pre-edge values. With A's select at 2'b10 and B's select at 2'b01, the two values are exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_bus_i | input | WIDTH | External data bus |
| sel_a_i | input | 2 | Source select for register A |
| sel_b_i | input | 2 | Source select for register B |
| fn_sel_i | input | 3 | Result function select |
| reg_a_o | output | WIDTH | Register A contents |
| reg_b_o | output | WIDTH | Register B contents |
| out_bus_o | output | WIDTH | Result bus |

## Verification
In one cycle, the result bus can be both an observed output and the value loaded into a register through source code 2'b11. This matters most when the operation wraps the sum or shifts a bit out. The bench provokes this case by selecting the sum of 0xF and 0x6 and a shift, with A's source set to the result bus. It checks the bus value before the edge against a model computed from the old registers. It then checks the register after the edge against that same pre-edge value. A register exchange on one edge covers the second overlap: two loads drawing on each other's old values.

// File: rtl/fbmux_alu_pkg.sv
package fbmux_alu_pkg;
  typedef enum logic [1:0] {
    SRC_IN  = 2'b00,
    SRC_A   = 2'b01,
    SRC_B   = 2'b10,
    SRC_RES = 2'b11
  } src_sel_e;

  typedef enum logic [2:0] {
    FN_PASS_A = 3'b000,
    FN_PASS_B = 3'b001,
    FN_NOT_A  = 3'b010,
    FN_AND    = 3'b011,
    FN_OR     = 3'b100,
    FN_ADD    = 3'b101,
    FN_SHL    = 3'b110,
    FN_SHR    = 3'b111
  } fn_sel_e;

  localparam int unsigned NUM_REGS = 2;
endpackage

// File: rtl/fbmux_src_mux.sv
module fbmux_src_mux
  import fbmux_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] in_bus_i,
  input  logic [WIDTH-1:0] reg_a_i,
  input  logic [WIDTH-1:0] reg_b_i,
  input  logic [WIDTH-1:0] res_i,
  output logic [WIDTH-1:0] d_o
);
  src_sel_e sel;
  assign sel = src_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SRC_IN:  d_o = in_bus_i;
      SRC_A:   d_o = reg_a_i;
      SRC_B:   d_o = reg_b_i;
      SRC_RES: d_o = res_i;
      default: d_o = in_bus_i;
    endcase
  end
endmodule

// File: rtl/fbmux_reg.sv
module fbmux_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // no enable: hold is a mux selecting q_o back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/fbmux_func_unit.sv
module fbmux_func_unit
  import fbmux_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       fn_i,
  output logic [WIDTH-1:0] y_o
);
  localparam int unsigned SUM_W = WIDTH + 1;

  fn_sel_e          fn;
  logic [SUM_W-1:0] sum_full;
  logic [WIDTH-1:0] shl, shr;

  assign fn       = fn_sel_e'(fn_i);
  assign sum_full = {1'b0, a_i} + {1'b0, b_i};
  assign shl      = {a_i[WIDTH-2:0], 1'b0};
  assign shr      = {1'b0, a_i[WIDTH-1:1]};

  always_comb begin
    unique case (fn)
      FN_PASS_A: y_o = a_i;
      FN_PASS_B: y_o = b_i;
      FN_NOT_A:  y_o = ~a_i;
      FN_AND:    y_o = a_i & b_i;
      FN_OR:     y_o = a_i | b_i;
      FN_ADD:    y_o = sum_full[WIDTH-1:0]; // carry dropped
      FN_SHL:    y_o = shl;
      FN_SHR:    y_o = shr;
      default:   y_o = a_i;
    endcase
  end
endmodule

// File: rtl/fbmux_alu.sv
module fbmux_alu
  import fbmux_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_bus_i,
  input  logic [1:0]       sel_a_i,
  input  logic [1:0]       sel_b_i,
  input  logic [2:0]       fn_sel_i,
  output logic [WIDTH-1:0] reg_a_o,
  output logic [WIDTH-1:0] reg_b_o,
  output logic [WIDTH-1:0] out_bus_o
);
  logic [NUM_REGS-1:0][WIDTH-1:0] q;
  logic [NUM_REGS-1:0][WIDTH-1:0] d;
  logic [NUM_REGS-1:0][1:0]       sel;
  logic [WIDTH-1:0]               res;

  assign sel[0] = sel_a_i;
  assign sel[1] = sel_b_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    fbmux_src_mux #(.WIDTH(WIDTH)) u_mux (
      .sel_i   (sel[g]),
      .in_bus_i(in_bus_i),
      .reg_a_i (q[0]),
      .reg_b_i (q[1]),
      .res_i   (res),
      .d_o     (d[g])
    );
    fbmux_reg #(.WIDTH(WIDTH)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (d[g]),
      .q_o   (q[g])
    );
  end

  fbmux_func_unit #(.WIDTH(WIDTH)) u_fu (
    .a_i (q[0]),
    .b_i (q[1]),
    .fn_i(fn_sel_i),
    .y_o (res)
  );

  assign reg_a_o   = q[0];
  assign reg_b_o   = q[1];
  assign out_bus_o = res;
endmodule

// File: rtl/fbmux_alu_chk.sv
module fbmux_alu_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] in_bus_i,
  input logic [1:0]       sel_a_i,
  input logic [1:0]       sel_b_i,
  input logic [2:0]       fn_sel_i,
  input logic [WIDTH-1:0] reg_a_o,
  input logic [WIDTH-1:0] reg_b_o,
  input logic [WIDTH-1:0] out_bus_o
);
  logic rst_q;
  always_ff @(posedge clk_i) rst_q <= !rst_ni;

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    (rst_q && !rst_ni) |-> (reg_a_o == '0 && reg_b_o == '0)); // R1

  AST_A_LOAD_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_a_i == 2'b00 |=> reg_a_o == $past(in_bus_i)); // R2
  AST_B_LOAD_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_b_i == 2'b00 |=> reg_b_o == $past(in_bus_i)); // R2
  AST_A_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_a_i == 2'b01 |=> $stable(reg_a_o)); // R3
  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_b_i == 2'b10 |=> $stable(reg_b_o)); // R3
  AST_A_FEEDBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_a_i == 2'b11 |=> reg_a_o == $past(out_bus_o)); // R4
  AST_B_FEEDBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_b_i == 2'b11 |=> reg_b_o == $past(out_bus_o)); // R4
  AST_PASS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_sel_i == 3'b000 |-> out_bus_o == reg_a_o); // R5
  AST_SUM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_sel_i == 3'b101 |-> out_bus_o == WIDTH'(reg_a_o + reg_b_o)); // R7
  AST_SHL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_sel_i == 3'b110 |-> out_bus_o[0] == 1'b0); // R8
  AST_SHR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_sel_i == 3'b111 |-> out_bus_o[WIDTH-1] == 1'b0); // R8
  AST_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_i == 2'b10 && sel_b_i == 2'b01) |=>
      (reg_a_o == $past(reg_b_o) && reg_b_o == $past(reg_a_o))); // R10
endmodule

bind fbmux_alu fbmux_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/fbmux_alu_tb_top.sv
`timescale 1ns/1ps
module fbmux_alu_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] in_bus = '0;
  logic [1:0]   sel_a = 2'b01, sel_b = 2'b10;
  logic [2:0]   fn = '0;
  logic [W-1:0] reg_a, reg_b, out_bus;

  always #2.5 clk = ~clk;

  fbmux_alu #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_bus_i(in_bus),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .fn_sel_i(fn),
    .reg_a_o(reg_a), .reg_b_o(reg_b), .out_bus_o(out_bus)
  );

  typedef struct {
    logic [W-1:0] a, b, o;
    string        ta, tb, to;
  } item_t;

  item_t        q[$];
  logic [W-1:0] m_a = '0, m_b = '0;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] model_fn(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    case (f)
      3'd0: return a;
      3'd1: return b;
      3'd2: return ~a;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return s[W-1:0];
      3'd6: return {a[W-2:0], 1'b0};
      default: return {1'b0, a[W-1:1]};
    endcase
  endfunction

  function automatic string fn_tag(logic [2:0] f);
    if (f <= 3'd2) return "R5";
    if (f <= 3'd4) return "R6";
    if (f == 3'd5) return "R7";
    return "R8";
  endfunction

  function automatic string src_tag(logic [1:0] s);
    case (s)
      2'b00: return "R2";
      2'b11: return "R4";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [W-1:0] pick(logic [1:0] s, logic [W-1:0] i,
                                        logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] o);
    case (s)
      2'b00: return i;
      2'b01: return a;
      2'b10: return b;
      default: return o;
    endcase
  endfunction

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(logic [W-1:0] i, logic [1:0] sa, logic [1:0] sb, logic [2:0] f, string tag = "");
    item_t it;
    logic [W-1:0] o;
    @(negedge clk);
    in_bus = i; sel_a = sa; sel_b = sb; fn = f;
    o = model_fn(m_a, m_b, f);
    it.o = o;
    it.a = pick(sa, i, m_a, m_b, o);
    it.b = pick(sb, i, m_a, m_b, o);
    it.to = {fn_tag(f), " R9 out"};
    it.ta = (tag != "") ? {tag, " regA"} : {src_tag(sa), " regA"};
    it.tb = (tag != "") ? {tag, " regB"} : {src_tag(sb), " regB"};
    q.push_back(it);
    m_a = it.a; m_b = it.b;
  endtask

  // monitor: result bus before the edge, registers after it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.to, out_bus, it.o);
        @(posedge clk);
        #1;
        chk(it.ta, reg_a, it.a);
        chk(it.tb, reg_b, it.b);
      end
    end
  end

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset regA", reg_a, '0);
    chk("R1 reset regB", reg_b, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    step(4'h9, 2'b00, 2'b10, 3'd0);          // A <= 9
    step(4'h6, 2'b01, 2'b00, 3'd1);          // B <= 6
    step(4'h3, 2'b01, 2'b10, 3'd0);          // pass A, holds, input ignored
    step(4'h3, 2'b01, 2'b10, 3'd1);
    step(4'h3, 2'b01, 2'b10, 3'd2);          // ~9 = 6
    step(4'h3, 2'b01, 2'b10, 3'd3);          // 0
    step(4'h3, 2'b01, 2'b10, 3'd4);          // F
    step(4'h0, 2'b11, 2'b10, 3'd5, "R4");    // A <= 9+6 = F
    step(4'h0, 2'b11, 2'b10, 3'd5, "R7");    // A <= F+6 wraps to 5
    step(4'h9, 2'b00, 2'b10, 3'd6);          // shl 5 = A, A <= 9
    step(4'h0, 2'b11, 2'b10, 3'd6, "R8");    // A <= 9<<1 = 2
    step(4'h9, 2'b00, 2'b10, 3'd7);
    step(4'h0, 2'b11, 2'b10, 3'd7, "R8");    // A <= 9>>1 = 4
    step(4'h0, 2'b10, 2'b01, 3'd4, "R10");   // swap
    step(4'h0, 2'b01, 2'b11, 3'd2, "R4");    // B <= ~A
    step(4'hC, 2'b10, 2'b00, 3'd5);          // A <= B, B <= C
    step(4'h0, 2'b01, 2'b01, 3'd3);          // B <= A

    // R9: result tracks function select with registers held
    drain();
    for (int f = 0; f < 8; f++) begin
      @(negedge clk);
      sel_a = 2'b01; sel_b = 2'b10; fn = 3'(f);
      #1;
      chk({fn_tag(3'(f)), " R9 comb"}, out_bus, model_fn(m_a, m_b, 3'(f)));
    end

    for (int i = 0; i < 48; i++)
      step(4'((i * 7 + 3) & 15), 2'(i % 4), 2'((i / 4) % 4), 3'((i * 3) % 8));

    // R1: asynchronous reset mid-cycle
    drain();
    @(negedge clk);
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk("R1 async regA", reg_a, '0);
    chk("R1 async regB", reg_b, '0);
    @(posedge clk); #1;
    chk("R1 held regA", reg_a, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_a = '0; m_b = '0;
    step(4'h5, 2'b00, 2'b00, 3'd5);
    step(4'h0, 2'b11, 2'b10, 3'd5, "R7");    // 5+5 = A
    drain();
    finish_run();
  end
endmodule